// File: doc/BRIEF.md
# DTMF Tone-Pair Decoder (Period Counting)

This block turns two clean one-bit square waves into telephone keypad digits. One square wave carries the low-frequency tone group and the other the high-frequency group; an earlier analog stage has already split, filtered and squared them. Each channel counts reference-clock cycles between successive rising edges. It checks every measured period against four frequency windows, each ±2% of the nominal period. A channel locks onto a bin once several periods in a row land in that bin.

When both channels are locked, `pair_present` rises and `pair_code` shows the 4-bit key code. Both fall as soon as either lock is lost. Each new onset of a pair is also offered once on a valid/ready output stream. The offered code holds until the consumer accepts it. An onset that comes while an earlier code is still waiting is discarded, so a slow consumer sees the oldest unread digit. `inhibit` stops pairs in the highest-frequency column from being reported. `pwdn` clears all detection state and holds every output low.

Top module: `dtmf_tone_decoder`

## Requirements
- R1: A channel locks onto a bin after RUNS (default 4) consecutive measured periods fall within nominal ± nominal/50 cycles, where nominal = round(CLK_HZ/f). Low bins are 697, 770, 852 and 941 Hz, numbered row 0..3. High bins are 1209, 1336, 1477 and 1633 Hz, numbered column 0..3. `pair_present` goes high when both channels are locked.
- R2: `pair_code` (and `out_code`) encode row/column as follows. Digits 1–9 map to 1–9, read row-major across columns 0..2 of rows 0..2. Key 0 (row 3, col 1) is 10. `*` (row 3, col 0) is 11. `#` (row 3, col 2) is 12. Column 3 gives 13, 14 and 15 for rows 0, 1 and 2, and 0 for row 3. `pair_code` is 0 whenever `pair_present` is low.
- R3: A period outside every bin, or no rising edge within 3/2 of the slowest bin's nominal period, clears that channel's lock. `pair_present` then falls.
- R4: A square wave whose period lies in no bin never produces `pair_present` or a stream word.
- R5: While `inhibit` is high, no pair in high column 3 (codes 13, 14, 15, 0) is reported on `pair_present`, `pair_code` or the stream. Other columns are still reported.
- R6: One cycle after `pwdn` is high, `pair_present`, `pair_code` and `out_valid` are 0, and they stay 0 while `pwdn` stays high. Detection resumes after `pwdn` is released.
- R7: Each rising edge of `pair_present` loads the pair's code into `out_code` and raises `out_valid`, provided no word is pending. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_code` stay unchanged. A cycle in which both are high consumes the word.
- R8: A pair onset that occurs while a word is pending is dropped. The pending word is delivered unchanged.
- R9: After reset, `pair_present`, `pair_code` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (CLK_HZ) |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_sq | input | 1 | Squared low-group signal |
| hi_sq | input | 1 | Squared high-group signal |
| inhibit | input | 1 | Reject high column 3 when high |
| pwdn | input | 1 | Power-down: clear and silence |
| pair_present | output | 1 | Early detect: valid pair right now |
| pair_code | output | 4 | Code of present pair, 0 otherwise |
| out_valid | output | 1 | Stream word available |
| out_ready | input | 1 | Consumer accepts word |
| out_code | output | 4 | Stream word: key code |

## Verification
All sixteen row/column combinations are driven at their nominal frequencies, each rounded to whole half-periods. This shows that every bin window and every code-table entry is distinct. A low-group frequency that fits no bin checks the rejection side of the windows. A high tone briefly moved off-bin checks that a single stray period drops the lock, and silence checks the timeout path. The inhibit test uses the 1633 Hz column against the 1477 Hz column, which shows the rejection is tied to one column only. Holding the consumer stalled across two onsets checks that the first word survives and the second is dropped.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  typedef logic [1:0] bin_t;
  typedef logic [3:0] code_t;

  function automatic int unsigned nominal_cycles(input int unsigned clk_hz,
                                                 input int unsigned freq_hz);
    return (clk_hz + freq_hz / 2) / freq_hz;
  endfunction

  // row = low-group bin, col = high-group bin
  function automatic code_t key_code(input bin_t row, input bin_t col);
    code_t c;
    if (row == 2'd3) begin
      case (col)
        2'd0:    c = 4'd11;
        2'd1:    c = 4'd10;
        2'd2:    c = 4'd12;
        default: c = 4'd0;
      endcase
    end else if (col == 2'd3) begin
      c = 4'd13 + {2'b00, row};
    end else begin
      c = 4'({row, 1'b0}) + {2'b00, row} + {2'b00, col} + 4'd1;
    end
    return c;
  endfunction
endpackage

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
  parameter int unsigned TIMEOUT = 537,
  parameter int unsigned CNT_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sq,
  output logic             per_stb,
  output logic             per_ok,
  output logic [CNT_W-1:0] per_cnt
);
  localparam logic [CNT_W-1:0] TO_C = CNT_W'(TIMEOUT);

  logic [2:0]       sync_q;
  logic             rise;
  logic             have_ref;
  logic [CNT_W-1:0] cnt;

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      have_ref <= 1'b0;
      cnt      <= '0;
      per_stb  <= 1'b0;
      per_ok   <= 1'b0;
      per_cnt  <= '0;
    end else if (clr) begin
      sync_q   <= '0;
      have_ref <= 1'b0;
      cnt      <= '0;
      per_stb  <= 1'b0;
      per_ok   <= 1'b0;
      per_cnt  <= '0;
    end else begin
      sync_q  <= {sync_q[1:0], sq};
      per_stb <= 1'b0;
      if (rise) begin
        if (have_ref) begin
          per_stb <= 1'b1;
          per_ok  <= 1'b1;
          per_cnt <= cnt;
        end
        cnt      <= CNT_W'(1);
        have_ref <= 1'b1;
      end else if (have_ref) begin
        if (cnt == TO_C) begin
          per_stb  <= 1'b1;
          per_ok   <= 1'b0;
          have_ref <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dtmf_bin_tracker.sv
module dtmf_bin_tracker
  import dtmf_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 3579545,
  parameter int unsigned FREQ_HZ[4] = '{697, 770, 852, 941},
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned RUNS       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             per_stb,
  input  logic             per_ok,
  input  logic [CNT_W-1:0] per_cnt,
  output logic             tone_ok,
  output bin_t             tone_bin
);
  localparam int unsigned RUN_W = $clog2(RUNS + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUNS);

  logic [3:0]       hit;
  logic             any_hit;
  bin_t             hit_bin;
  bin_t             cur_bin;
  logic [RUN_W-1:0] run;

  for (genvar b = 0; b < 4; b++) begin : g_bin
    localparam int unsigned NOM = nominal_cycles(CLK_HZ, FREQ_HZ[b]);
    localparam int unsigned TOL = NOM / 50;
    localparam logic [CNT_W-1:0] LO_C = CNT_W'(NOM - TOL);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(NOM + TOL);
    assign hit[b] = per_ok && (per_cnt >= LO_C) && (per_cnt <= HI_C);
  end

  always_comb begin
    any_hit = |hit;
    hit_bin = 2'd0;
    for (int i = 0; i < 4; i++) begin
      if (hit[i]) hit_bin = bin_t'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bin <= '0;
      run     <= '0;
    end else if (clr) begin
      cur_bin <= '0;
      run     <= '0;
    end else if (per_stb) begin
      if (!any_hit) begin
        run <= '0;
      end else if (hit_bin == cur_bin && run != '0) begin
        if (run != RUN_MAX) run <= run + 1'b1;
      end else begin
        cur_bin <= hit_bin;
        run     <= RUN_W'(1);
      end
    end
  end

  assign tone_ok  = (run == RUN_MAX);
  assign tone_bin = cur_bin;
endmodule

// File: rtl/dtmf_pair_stream.sv
module dtmf_pair_stream
  import dtmf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lo_ok,
  input  bin_t  lo_bin,
  input  logic  hi_ok,
  input  bin_t  hi_bin,
  input  logic  inhibit,
  input  logic  pwdn,
  output logic  pair_present,
  output code_t pair_code,
  output logic  out_valid,
  input  logic  out_ready,
  output code_t out_code
);
  logic  pair_ok;
  code_t code_now;

  assign pair_ok  = lo_ok && hi_ok && !pwdn && !(inhibit && hi_bin == 2'd3);
  assign code_now = key_code(lo_bin, hi_bin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_present <= 1'b0;
      pair_code    <= '0;
      out_valid    <= 1'b0;
      out_code     <= '0;
    end else if (pwdn) begin
      pair_present <= 1'b0;
      pair_code    <= '0;
      out_valid    <= 1'b0;
    end else begin
      pair_present <= pair_ok;
      pair_code    <= pair_ok ? code_now : '0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (pair_ok && !pair_present && !out_valid) begin
        out_valid <= 1'b1;
        out_code  <= code_now;
      end
    end
  end
endmodule

// File: rtl/dtmf_tone_decoder.sv
module dtmf_tone_decoder
  import dtmf_pkg::*;
#(
  parameter int unsigned CLK_HZ = 3579545,
  parameter int unsigned RUNS   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_sq,
  input  logic       hi_sq,
  input  logic       inhibit,
  input  logic       pwdn,
  output logic       pair_present,
  output logic [3:0] pair_code,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [3:0] out_code
);
  localparam int unsigned LO_TO = nominal_cycles(CLK_HZ, 697) * 3 / 2;
  localparam int unsigned HI_TO = nominal_cycles(CLK_HZ, 1209) * 3 / 2;
  localparam int unsigned CNT_W = $clog2(LO_TO + 1);
  localparam int unsigned LOW_HZ [4] = '{697, 770, 852, 941};
  localparam int unsigned HIGH_HZ[4] = '{1209, 1336, 1477, 1633};

  logic             lo_stb, lo_pok, hi_stb, hi_pok;
  logic [CNT_W-1:0] lo_cnt, hi_cnt;
  logic             lo_ok, hi_ok;
  bin_t             lo_bin, hi_bin;

  dtmf_period_meter #(.TIMEOUT(LO_TO), .CNT_W(CNT_W)) u_lo_meter (
    .clk(clk), .rst_n(rst_n), .clr(pwdn), .sq(lo_sq),
    .per_stb(lo_stb), .per_ok(lo_pok), .per_cnt(lo_cnt));

  dtmf_period_meter #(.TIMEOUT(HI_TO), .CNT_W(CNT_W)) u_hi_meter (
    .clk(clk), .rst_n(rst_n), .clr(pwdn), .sq(hi_sq),
    .per_stb(hi_stb), .per_ok(hi_pok), .per_cnt(hi_cnt));

  dtmf_bin_tracker #(.CLK_HZ(CLK_HZ), .FREQ_HZ(LOW_HZ), .CNT_W(CNT_W), .RUNS(RUNS)) u_lo_bins (
    .clk(clk), .rst_n(rst_n), .clr(pwdn), .per_stb(lo_stb), .per_ok(lo_pok),
    .per_cnt(lo_cnt), .tone_ok(lo_ok), .tone_bin(lo_bin));

  dtmf_bin_tracker #(.CLK_HZ(CLK_HZ), .FREQ_HZ(HIGH_HZ), .CNT_W(CNT_W), .RUNS(RUNS)) u_hi_bins (
    .clk(clk), .rst_n(rst_n), .clr(pwdn), .per_stb(hi_stb), .per_ok(hi_pok),
    .per_cnt(hi_cnt), .tone_ok(hi_ok), .tone_bin(hi_bin));

  dtmf_pair_stream u_stream (
    .clk(clk), .rst_n(rst_n), .lo_ok(lo_ok), .lo_bin(lo_bin), .hi_ok(hi_ok),
    .hi_bin(hi_bin), .inhibit(inhibit), .pwdn(pwdn), .pair_present(pair_present),
    .pair_code(pair_code), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code));
endmodule

// File: rtl/dtmf_decoder_checks.sv
module dtmf_decoder_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       inhibit,
  input logic       pwdn,
  input logic       pair_present,
  input logic [3:0] pair_code,
  input logic       out_valid,
  input logic       out_ready,
  input logic [3:0] out_code
);
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !pwdn) |=> (out_valid && $stable(out_code)));

  assert_onset_emit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($rose(pair_present) && out_code == pair_code));

  assert_pwdn_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwdn |=> (!pair_present && !out_valid && pair_code == 4'd0));

  assert_inhibit_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !(pair_present &&
                  (pair_code == 4'd0 || pair_code == 4'd13 ||
                   pair_code == 4'd14 || pair_code == 4'd15)));

  assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_present |-> (pair_code == 4'd0));
endmodule

bind dtmf_tone_decoder dtmf_decoder_checks u_checks (
  .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .pwdn(pwdn),
  .pair_present(pair_present), .pair_code(pair_code), .out_valid(out_valid),
  .out_ready(out_ready), .out_code(out_code));

// File: tb/sim_dtmf_tone_decoder.sv
`timescale 1ns/1ps
module sim_dtmf_tone_decoder;
  localparam int unsigned CLK_HZ = 250000;
  localparam int unsigned LOW_HZ [4] = '{697, 770, 852, 941};
  localparam int unsigned HIGH_HZ[4] = '{1209, 1336, 1477, 1633};
  localparam int DETECT_WAIT = 2400;
  localparam int DROP_WAIT   = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lo_sq = 1'b0, hi_sq = 1'b0;
  logic       inhibit = 1'b0, pwdn = 1'b0, out_ready = 1'b0;
  logic       pair_present, out_valid;
  logic [3:0] pair_code, out_code;
  int         lo_half = 0, hi_half = 0;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  dtmf_tone_decoder #(.CLK_HZ(CLK_HZ), .RUNS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .lo_sq(lo_sq), .hi_sq(hi_sq), .inhibit(inhibit),
    .pwdn(pwdn), .pair_present(pair_present), .pair_code(pair_code),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code));

  always begin
    if (lo_half == 0) begin lo_sq = 1'b0; @(negedge clk); end
    else begin repeat (lo_half) @(negedge clk); lo_sq = ~lo_sq; end
  end
  always begin
    if (hi_half == 0) begin hi_sq = 1'b0; @(negedge clk); end
    else begin repeat (hi_half) @(negedge clk); hi_sq = ~hi_sq; end
  end

  function automatic int half_of(input int unsigned f);
    return (CLK_HZ + f) / (2 * f);
  endfunction

  function automatic logic [3:0] expect_code(input int r, input int c);
    case ({r[1:0], c[1:0]})
      4'b0000: return 4'd1;  4'b0001: return 4'd2;  4'b0010: return 4'd3;  4'b0011: return 4'd13;
      4'b0100: return 4'd4;  4'b0101: return 4'd5;  4'b0110: return 4'd6;  4'b0111: return 4'd14;
      4'b1000: return 4'd7;  4'b1001: return 4'd8;  4'b1010: return 4'd9;  4'b1011: return 4'd15;
      4'b1100: return 4'd11; 4'b1101: return 4'd10; 4'b1110: return 4'd12; default: return 4'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tones(input int r, input int c);
    lo_half = (r < 0) ? 0 : half_of(LOW_HZ[r]);
    hi_half = (c < 0) ? 0 : half_of(HIGH_HZ[c]);
  endtask

  task automatic silence_and_flush();
    tones(-1, -1);
    out_ready = 1'b1;
    wait_cyc(DROP_WAIT);
    out_ready = 1'b0;
    wait_cyc(2);
  endtask

  task automatic test_reset();
    wait_cyc(3);
    check(pair_present == 1'b0, "R9 present", pair_present, 0);
    check(out_valid == 1'b0, "R9 valid", out_valid, 0);
    check(pair_code == 4'd0, "R9 code", pair_code, 0);
  endtask

  task automatic test_all_keys();
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        tones(r, c);
        wait_cyc(DETECT_WAIT);
        check(pair_present == 1'b1, "R1 lock", pair_present, 1);
        check(pair_code == expect_code(r, c), "R2 level code", pair_code, expect_code(r, c));
        check(out_valid == 1'b1, "R7 offered", out_valid, 1);
        check(out_code == expect_code(r, c), "R2 stream code", out_code, expect_code(r, c));
        out_ready = 1'b1;
        wait_cyc(1);
        out_ready = 1'b0;
        check(out_valid == 1'b0, "R7 consumed", out_valid, 0);
        tones(-1, -1);
        wait_cyc(DROP_WAIT);
        check(pair_present == 1'b0, "R3 timeout drop", pair_present, 0);
        check(out_valid == 1'b0, "R7 single word", out_valid, 0);
      end
    end
  endtask

  task automatic test_off_bin();
    lo_half = half_of(1000);
    hi_half = half_of(HIGH_HZ[1]);
    wait_cyc(DETECT_WAIT);
    check(pair_present == 1'b0, "R4 no lock", pair_present, 0);
    check(out_valid == 1'b0, "R4 no word", out_valid, 0);
    silence_and_flush();
  endtask

  task automatic test_glitch();
    tones(1, 2);
    wait_cyc(DETECT_WAIT);
    check(pair_present == 1'b1, "R3 pre-lock", pair_present, 1);
    out_ready = 1'b1; wait_cyc(1); out_ready = 1'b0;
    hi_half = half_of(1400);
    wait_cyc(400);
    check(pair_present == 1'b0, "R3 stray period drop", pair_present, 0);
    tones(1, 2);
    wait_cyc(DETECT_WAIT);
    check(pair_present == 1'b1, "R3 relock", pair_present, 1);
    check(out_valid == 1'b1 && out_code == 4'd6, "R7 new onset word", out_code, 6);
    silence_and_flush();
  endtask

  task automatic test_inhibit();
    inhibit = 1'b1;
    tones(0, 3);
    wait_cyc(DETECT_WAIT);
    check(pair_present == 1'b0, "R5 column blocked", pair_present, 0);
    check(out_valid == 1'b0, "R5 no word", out_valid, 0);
    tones(3, 3);
    wait_cyc(DETECT_WAIT);
    check(pair_present == 1'b0, "R5 D blocked", pair_present, 0);
    tones(0, 2);
    wait_cyc(DETECT_WAIT);
    check(pair_present == 1'b1 && pair_code == 4'd3, "R5 other column", pair_code, 3);
    inhibit = 1'b0;
    silence_and_flush();
  endtask

  task automatic test_pwdn();
    tones(1, 1);
    wait_cyc(DETECT_WAIT);
    check(pair_present == 1'b1 && out_valid == 1'b1, "R6 pre", pair_present, 1);
    pwdn = 1'b1;
    wait_cyc(1);
    check(pair_present == 1'b0, "R6 present off", pair_present, 0);
    check(out_valid == 1'b0, "R6 valid off", out_valid, 0);
    wait_cyc(DROP_WAIT);
    check(pair_present == 1'b0 && pair_code == 4'd0, "R6 held", pair_code, 0);
    pwdn = 1'b0;
    wait_cyc(DETECT_WAIT);
    check(pair_present == 1'b1 && pair_code == 4'd5, "R6 resume", pair_code, 5);
    silence_and_flush();
  endtask

  task automatic test_backpressure();
    out_ready = 1'b0;
    tones(0, 0);
    wait_cyc(DETECT_WAIT);
    tones(-1, -1);
    wait_cyc(DROP_WAIT);
    tones(1, 1);
    wait_cyc(DETECT_WAIT);
    check(pair_present == 1'b1 && pair_code == 4'd5, "R8 second pair live", pair_code, 5);
    check(out_valid == 1'b1, "R8 pending", out_valid, 1);
    check(out_code == 4'd1, "R8 oldest kept", out_code, 1);
    out_ready = 1'b1; wait_cyc(1); out_ready = 1'b0;
    check(out_valid == 1'b0, "R8 second dropped", out_valid, 0);
    silence_and_flush();
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    test_reset();
    test_all_keys();
    test_off_bin();
    test_glitch();
    test_inhibit();
    test_pwdn();
    test_backpressure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule